// File: doc/BRIEF.md
# Priority Crossbar Pin Allocator

This block places the signals of a fixed set of on-chip digital peripherals onto 32 external pins, organised as four 8-bit ports. Configuration inputs say which peripheral groups are active. The allocator packs every enabled signal, in a fixed signal order, onto the lowest-numbered free pins. Because of this packing, enabling a higher-priority group moves every lower-priority signal to a higher pin. Pins that no signal claims work as general-purpose outputs driven from the port latch bits.

Assignment is purely combinational from the configuration. The only sequential logic is a small counter that divides the clock for the clock-output signal. Each pin can be set to push-pull or open-drain. The eight pins of port 1 can each be reserved as analog inputs. A reserved pin is skipped by the packing, never driven, and reads as 0.

Top module: `xbar_alloc`

## Requirements
- R1: Signal slots, from highest to lowest priority, are: UART0 0-1 (`cfg_en[0]`), SPI 2-5 (`cfg_en[1]`), SMBus 6-7 (`cfg_en[2]`), UART1 8-9 (`cfg_en[3]`), PCA 10-16, comparators 17-18 (`cfg_en[4]`), timers and interrupts 19-26 (`cfg_en[5]`), clock output 27 (`cfg_en[6]`), converter starts 28-29 (`cfg_en[7]`). The k-th enabled slot in this order gets the k-th available pin, counted upward from pin 0; pin p is port p/8, bit p%8.
- R2: A pin receives at most one slot. A digital pin that no slot claims drives `port_latch[p]` with an enable of 1, before the mode of R5 is applied.
- R3: `pca_cnt` = n (0 to 7) enables PCA slots 10 through 10+n-1, and only those slots.
- R4: When more slots are enabled than there are digital pins, `overflow` is 1 and the lowest-priority slots that do not fit get no pin. Otherwise `overflow` is 0.
- R5: For a claimed pin, `pin_out` equals the slot's `per_out` and the enable is the slot's `per_oe`. With `pin_pp[p]`=1 (push-pull) that enable goes to `pin_oe[p]` unchanged. With `pin_pp[p]`=0 (open-drain), `pin_oe[p]` = enable AND NOT `pin_out[p]`.
- R6: When `analog_p1[i]`=1, pin 8+i is skipped by the packing, has `pin_oe` 0, and reads 0 on `port_rd`.
- R7: For every digital pin, `port_rd[p]` equals `pin_in[p]`, whether the pin is claimed by a slot or used as general-purpose output.
- R8: `per_in[s]` equals `pin_in` of the pin that slot s holds. A slot that holds no pin reads 1.
- R9: The value of slot 27 is the divided clock AND `per_out[27]`. The divider is selected by `clk_div` (0: clk, 1: /2, 2: /4, 3: /8) and taken from a 3-bit counter that reset clears and that increments on each rising clock edge. For /2^m, the output is counter bit m-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock for the clock-output divider |
| rst_n | input | 1 | active-low asynchronous reset of the divider |
| cfg_en | input | 8 | group enables, bit mapping per R1 |
| pca_cnt | input | 3 | number of PCA slots routed |
| clk_div | input | 2 | clock-output divide select |
| analog_p1 | input | 8 | port 1 analog reservation, one bit per pin |
| pin_pp | input | 32 | 1 = push-pull, 0 = open-drain, per pin |
| port_latch | input | 32 | general-purpose output values |
| per_out | input | 30 | peripheral output value per slot |
| per_oe | input | 30 | peripheral output enable per slot |
| per_in | output | 30 | pin level routed back to each slot |
| pin_in | input | 32 | level seen at each pin |
| pin_out | output | 32 | value driven on each pin |
| pin_oe | output | 32 | driver enable on each pin |
| port_rd | output | 32 | port data read-back |
| overflow | output | 1 | more slots enabled than pins available |

## Verification
The bench checks the shift that one enabled group causes in all later groups. A design that used fixed pin positions would leave SPI on pins 0-3 after UART0 is enabled. It walks every PCA count from 0 to 7, where an off-by-one in the count comparison routes one PCA signal too many or too few. It reserves all analog pins with every group enabled, which forces overflow. A design that counted reserved pins as free would drive them and mis-place every later signal. Random enable patterns are compared with a packing model, and the clock divider is followed edge by edge for each ratio.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    localparam int PORT_W  = 8;
    localparam int NPORT   = 4;
    localparam int NPIN    = PORT_W * NPORT;
    localparam int AN_PORT = 1;
    localparam int PCA_MAX = 7;
    localparam int NGRP    = 8;
    // slot bases in priority order
    localparam int U0_B  = 0;
    localparam int SPI_B = U0_B + 2;
    localparam int SMB_B = SPI_B + 4;
    localparam int U1_B  = SMB_B + 2;
    localparam int PCA_B = U1_B + 2;
    localparam int CMP_B = PCA_B + PCA_MAX;
    localparam int TMR_B = CMP_B + 2;
    localparam int CLK_B = TMR_B + 8;
    localparam int CNV_B = CLK_B + 1;
    localparam int NSIG  = CNV_B + 2;
    localparam int RW    = $clog2(NPIN + 1);
    localparam int DIVW  = 3;

    typedef enum logic [1:0] {DIV1 = 2'd0, DIV2 = 2'd1, DIV4 = 2'd2, DIV8 = 2'd3} clk_div_e;
endpackage

// File: rtl/xbar_clkdiv.sv
module xbar_clkdiv
    import xbar_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    output logic       clk_o
);
    logic [DIVW-1:0] cnt_q;
    clk_div_e        sel_e;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        sel_e = clk_div_e'(sel);
        unique case (sel_e)
            DIV1: clk_o = clk;
            DIV2: clk_o = cnt_q[0];
            DIV4: clk_o = cnt_q[1];
            DIV8: clk_o = cnt_q[2];
            default: clk_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/xbar_slot_map.sv
module xbar_slot_map
    import xbar_pkg::*;
(
    input  logic [NGRP-1:0]             cfg_en,
    input  logic [2:0]                  pca_cnt,
    input  logic [PORT_W-1:0]           analog_p1,
    output logic [NPIN-1:0]             dig,
    output logic [NSIG-1:0][NPIN-1:0]   own,
    output logic                        overflow
);
    logic [NSIG-1:0]         slot_en;
    logic [NSIG-1:0][RW-1:0] srank;
    logic [NPIN-1:0][RW-1:0] prank;
    logic [RW-1:0]           tot_en;
    logic [RW-1:0]           tot_dig;

    always_comb begin
        slot_en = '0;
        slot_en[U0_B  +: 2] = {2{cfg_en[0]}};
        slot_en[SPI_B +: 4] = {4{cfg_en[1]}};
        slot_en[SMB_B +: 2] = {2{cfg_en[2]}};
        slot_en[U1_B  +: 2] = {2{cfg_en[3]}};
        for (int i = 0; i < PCA_MAX; i++)
            slot_en[PCA_B + i] = (3'(i) < pca_cnt);
        slot_en[CMP_B +: 2] = {2{cfg_en[4]}};
        slot_en[TMR_B +: 8] = {8{cfg_en[5]}};
        slot_en[CLK_B]      = cfg_en[6];
        slot_en[CNV_B +: 2] = {2{cfg_en[7]}};
    end

    always_comb begin
        for (int p = 0; p < NPIN; p++) begin
            if (p / PORT_W == AN_PORT) dig[p] = !analog_p1[p % PORT_W];
            else                       dig[p] = 1'b1;
        end
    end

    // running ranks: position of each slot among enabled slots, each pin among digital pins
    always_comb begin
        tot_en = '0;
        for (int s = 0; s < NSIG; s++) begin
            srank[s] = tot_en;
            tot_en   = tot_en + RW'(slot_en[s]);
        end
        tot_dig = '0;
        for (int p = 0; p < NPIN; p++) begin
            prank[p] = tot_dig;
            tot_dig  = tot_dig + RW'(dig[p]);
        end
    end

    always_comb begin
        for (int s = 0; s < NSIG; s++)
            for (int p = 0; p < NPIN; p++)
                own[s][p] = slot_en[s] && dig[p] && (srank[s] == prank[p]);
    end

    assign overflow = (tot_en > tot_dig);
endmodule

// File: rtl/xbar_pin_mux.sv
module xbar_pin_mux
    import xbar_pkg::*;
(
    input  logic [NSIG-1:0][NPIN-1:0] own,
    input  logic [NPIN-1:0]           dig,
    input  logic [NSIG-1:0]           sig_out,
    input  logic [NSIG-1:0]           sig_oe,
    input  logic [NPIN-1:0]           pin_pp,
    input  logic [NPIN-1:0]           port_latch,
    input  logic [NPIN-1:0]           pin_in,
    output logic [NPIN-1:0]           pin_out,
    output logic [NPIN-1:0]           pin_oe,
    output logic [NSIG-1:0]           sig_in,
    output logic [NPIN-1:0]           port_rd
);
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic claimed, v, e;
        always_comb begin
            claimed = 1'b0;
            v       = 1'b0;
            e       = 1'b0;
            for (int s = 0; s < NSIG; s++) begin
                claimed = claimed | own[s][p];
                v       = v | (own[s][p] & sig_out[s]);
                e       = e | (own[s][p] & sig_oe[s]);
            end
            if (!claimed) begin
                v = port_latch[p];
                e = 1'b1;
            end
            pin_out[p] = v;
            if (!dig[p])        pin_oe[p] = 1'b0;
            else if (pin_pp[p]) pin_oe[p] = e;
            else                pin_oe[p] = e & ~v;
            port_rd[p] = dig[p] & pin_in[p];
        end
    end

    for (genvar s = 0; s < NSIG; s++) begin : g_sig
        assign sig_in[s] = (|own[s]) ? |(own[s] & pin_in) : 1'b1;
    end
endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc
    import xbar_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NGRP-1:0]      cfg_en,
    input  logic [2:0]           pca_cnt,
    input  logic [1:0]           clk_div,
    input  logic [PORT_W-1:0]    analog_p1,
    input  logic [NPIN-1:0]      pin_pp,
    input  logic [NPIN-1:0]      port_latch,
    input  logic [NSIG-1:0]      per_out,
    input  logic [NSIG-1:0]      per_oe,
    output logic [NSIG-1:0]      per_in,
    input  logic [NPIN-1:0]      pin_in,
    output logic [NPIN-1:0]      pin_out,
    output logic [NPIN-1:0]      pin_oe,
    output logic [NPIN-1:0]      port_rd,
    output logic                 overflow
);
    logic                       div_clk;
    logic [NPIN-1:0]            dig;
    logic [NSIG-1:0][NPIN-1:0]  own;
    logic [NSIG-1:0]            sig_out;

    xbar_clkdiv u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (clk_div),
        .clk_o (div_clk)
    );

    xbar_slot_map u_map (
        .cfg_en    (cfg_en),
        .pca_cnt   (pca_cnt),
        .analog_p1 (analog_p1),
        .dig       (dig),
        .own       (own),
        .overflow  (overflow)
    );

    always_comb begin
        sig_out        = per_out;
        sig_out[CLK_B] = div_clk & per_out[CLK_B];
    end

    xbar_pin_mux u_mux (
        .own        (own),
        .dig        (dig),
        .sig_out    (sig_out),
        .sig_oe     (per_oe),
        .pin_pp     (pin_pp),
        .port_latch (port_latch),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .sig_in     (per_in),
        .port_rd    (port_rd)
    );
endmodule

// File: rtl/xbar_alloc_chk.sv
module xbar_alloc_chk
    import xbar_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic [1:0]                 clk_div,
    input logic [PORT_W-1:0]          analog_p1,
    input logic [NPIN-1:0]            pin_pp,
    input logic [NPIN-1:0]            pin_in,
    input logic [NPIN-1:0]            pin_out,
    input logic [NPIN-1:0]            pin_oe,
    input logic [NPIN-1:0]            port_rd,
    input logic                       div_clk,
    input logic [NSIG-1:0][NPIN-1:0]  own
);
    logic [NPIN-1:0][NSIG-1:0] own_t;
    logic [NPIN-1:0]           an_mask;

    always_comb begin
        for (int p = 0; p < NPIN; p++)
            for (int s = 0; s < NSIG; s++)
                own_t[p][s] = own[s][p];
        an_mask = '0;
        an_mask[AN_PORT*PORT_W +: PORT_W] = analog_p1;
    end

    for (genvar p = 0; p < NPIN; p++) begin : g_one
        a_r2_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(own_t[p]));
    end

    a_r5_od_release: assert property (@(posedge clk) disable iff (!rst_n)
        (~pin_pp & pin_oe & pin_out) == '0);

    a_r6_analog_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (an_mask & pin_oe) == '0);

    a_r6_analog_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (an_mask & port_rd) == '0);

    a_r7_read_digital: assert property (@(posedge clk) disable iff (!rst_n)
        ((port_rd ^ pin_in) & ~an_mask) == '0);

    a_r9_div2_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_div == 2'd1 && $past(clk_div) == 2'd1 && $past(rst_n)) |-> (div_clk != $past(div_clk)));
endmodule

bind xbar_alloc xbar_alloc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_div   (clk_div),
    .analog_p1 (analog_p1),
    .pin_pp    (pin_pp),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .port_rd   (port_rd),
    .div_clk   (div_clk),
    .own       (own)
);

// File: tb/sim_xbar_alloc.sv
module sim_xbar_alloc;
    import xbar_pkg::*;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      cfg_en = '0;
    logic [2:0]      pca_cnt = '0;
    logic [1:0]      clk_div = '0;
    logic [7:0]      analog_p1 = '0;
    logic [31:0]     pin_pp = '1;
    logic [31:0]     port_latch = '0;
    logic [29:0]     per_out = '0;
    logic [29:0]     per_oe = '0;
    logic [29:0]     per_in;
    logic [31:0]     pin_in = '0;
    logic [31:0]     pin_out, pin_oe, port_rd;
    logic            overflow;

    int total = 0;
    int bad = 0;
    int pos = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) begin
        if (!rst_n) pos <= 0;
        else        pos <= pos + 1;
    end

    xbar_alloc u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .pca_cnt(pca_cnt), .clk_div(clk_div),
        .analog_p1(analog_p1), .pin_pp(pin_pp), .port_latch(port_latch),
        .per_out(per_out), .per_oe(per_oe), .per_in(per_in), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .port_rd(port_rd), .overflow(overflow)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference packing model built from the requirements
    task automatic model_check(string tag);
        bit   en [30];
        int   plist [32];
        int   owner [32];
        int   spin [30];
        int   nd = 0;
        int   k = 0;
        logic [31:0] e_out, e_oe, e_rd;
        logic [29:0] e_in;
        #1;
        for (int s = 0; s < 30; s++) en[s] = 0;
        for (int s = 0; s < 2; s++) en[s] = cfg_en[0];
        for (int s = 2; s < 6; s++) en[s] = cfg_en[1];
        for (int s = 6; s < 8; s++) en[s] = cfg_en[2];
        for (int s = 8; s < 10; s++) en[s] = cfg_en[3];
        for (int s = 0; s < 7; s++) en[10+s] = (s < int'(pca_cnt));
        for (int s = 17; s < 19; s++) en[s] = cfg_en[4];
        for (int s = 19; s < 27; s++) en[s] = cfg_en[5];
        en[27] = cfg_en[6];
        for (int s = 28; s < 30; s++) en[s] = cfg_en[7];
        for (int p = 0; p < 32; p++) begin
            owner[p] = -1;
            if (!(p >= 8 && p < 16 && analog_p1[p-8])) begin
                plist[nd] = p;
                nd++;
            end
        end
        for (int s = 0; s < 30; s++) begin
            spin[s] = -1;
            if (en[s]) begin
                if (k < nd) begin
                    spin[s] = plist[k];
                    owner[plist[k]] = s;
                end
                k++;
            end
        end
        for (int p = 0; p < 32; p++) begin
            bit an = (p >= 8 && p < 16 && analog_p1[p-8]);
            logic v, e;
            if (owner[p] >= 0) begin v = per_out[owner[p]]; e = per_oe[owner[p]]; end
            else begin v = port_latch[p]; e = 1'b1; end
            e_out[p] = v;
            e_oe[p]  = an ? 1'b0 : (pin_pp[p] ? e : (e & ~v));
            e_rd[p]  = an ? 1'b0 : pin_in[p];
        end
        for (int s = 0; s < 30; s++) e_in[s] = (spin[s] >= 0) ? pin_in[spin[s]] : 1'b1;
        chk({tag, " R1 pin_out"}, 64'(pin_out), 64'(e_out));
        chk({tag, " R5 pin_oe"}, 64'(pin_oe), 64'(e_oe));
        chk({tag, " R8 per_in"}, 64'(per_in), 64'(e_in));
        chk({tag, " R7 port_rd"}, 64'(port_rd), 64'(e_rd));
        chk({tag, " R4 overflow"}, 64'(overflow), 64'(k > nd));
    endtask

    task automatic t_reset();
        cfg_en = '0; pca_cnt = '0; analog_p1 = '0; pin_pp = '1;
        port_latch = 32'hA5C3_0FF1; pin_in = 32'h1234_5678;
        per_out = 30'h3FFF_FFFF; per_oe = 30'h3FFF_FFFF;
        #1;
        chk("R2 reset gpio out", 64'(pin_out), 64'(32'hA5C3_0FF1));
        chk("R2 reset gpio oe", 64'(pin_oe), 64'(32'hFFFF_FFFF));
        chk("R4 reset no overflow", 64'(overflow), 64'd0);
        chk("R8 reset per_in idle", 64'(per_in), 64'(30'h3FFF_FFFF));
    endtask

    task automatic t_shift();
        per_out = 30'h2AAA_AAAA; per_oe = '1; pin_in = 32'h0000_0005;
        port_latch = '0;
        cfg_en = 8'b0000_0010;   // SPI only
        #1;
        chk("R1 spi alone on pins 0-3", 64'(pin_out[3:0]), 64'(per_out[5:2]));
        chk("R8 spi slot2 from pin0", 64'(per_in[2]), 64'(pin_in[0]));
        model_check("spi");
        cfg_en = 8'b0000_0011;   // add UART0: SPI moves up by two
        #1;
        chk("R1 uart0 on pins 0-1", 64'(pin_out[1:0]), 64'(per_out[1:0]));
        chk("R1 spi shifted to pins 2-5", 64'(pin_out[5:2]), 64'(per_out[5:2]));
        chk("R8 spi slot2 from pin2", 64'(per_in[2]), 64'(pin_in[2]));
        model_check("uart0+spi");
    endtask

    task automatic t_pca();
        cfg_en = '0; port_latch = 32'hFFFF_FFFF; per_out = '0; per_oe = '1;
        for (int n = 0; n < 8; n++) begin
            pca_cnt = 3'(n);
            #1;
            chk($sformatf("R3 pca %0d gpio above", n), 64'(pin_out >> n), 64'(32'hFFFF_FFFF >> n));
            model_check($sformatf("R3 pca %0d", n));
        end
        pca_cnt = '0;
    endtask

    task automatic t_analog();
        cfg_en = 8'b1011_1111; pca_cnt = 3'd7; analog_p1 = 8'hFF;
        per_out = 30'h1555_5555; per_oe = '1; pin_in = '1;
        #1;
        chk("R6 analog pins undriven", 64'(pin_oe[15:8]), 64'd0);
        chk("R6 analog pins read 0", 64'(port_rd[15:8]), 64'd0);
        chk("R4 overflow with 29 over 24", 64'(overflow), 64'd1);
        chk("R4 last slot gets no pin", 64'(per_in[29]), 64'd1);
        model_check("R6 all analog");
        analog_p1 = 8'h0F;
        model_check("R6 half analog");
        analog_p1 = '0;
        model_check("R4 29 fit");
        chk("R4 no overflow", 64'(overflow), 64'd0);
    endtask

    task automatic t_odmode();
        cfg_en = 8'b0000_0001; pca_cnt = '0;
        pin_pp = 32'hFFFF_0000; port_latch = 32'h0F0F_0F0F;
        per_out = 30'h1; per_oe = 30'h3;
        #1;
        chk("R5 od latch1 released", 64'(pin_oe[2]), 64'd0);
        chk("R5 od latch0 driven", 64'(pin_oe[4]), 64'd1);
        chk("R5 od periph 1 released", 64'(pin_oe[0]), 64'd0);
        chk("R5 od periph 0 driven", 64'(pin_oe[1]), 64'd1);
        chk("R5 pp latch1 driven", 64'(pin_oe[16]), 64'd1);
        model_check("R5 mixed");
        pin_pp = '1;
    endtask

    task automatic t_readback();
        cfg_en = 8'b0000_0111; pin_in = 32'hDEAD_BEEF; per_oe = '1;
        #1;
        chk("R7 read assigned pins", 64'(port_rd[7:0]), 64'(8'hEF));
        chk("R7 read gpio pins", 64'(port_rd[31:8]), 64'(24'hDEADBE));
    endtask

    task automatic t_random();
        for (int i = 0; i < 40; i++) begin
            cfg_en = 8'($urandom) & 8'b1011_1111;
            pca_cnt = 3'($urandom);
            analog_p1 = 8'($urandom);
            pin_pp = $urandom; port_latch = $urandom; pin_in = $urandom;
            per_out = 30'($urandom); per_oe = 30'($urandom);
            model_check($sformatf("R1 random %0d", i));
        end
    endtask

    task automatic t_clkdiv();
        cfg_en = 8'b0100_0000; pca_cnt = '0; analog_p1 = '0; pin_pp = '1;
        per_out = '1; per_oe = '1;
        for (int sel = 0; sel < 4; sel++) begin
            clk_div = 2'(sel);
            @(negedge clk); rst_n = 1'b0;
            @(negedge clk); rst_n = 1'b1;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk); #1;
                if (sel == 0)
                    chk("R9 div1 low phase", 64'(pin_out[0]), 64'd0);
                else
                    chk($sformatf("R9 div sel %0d edge %0d", sel, pos), 64'(pin_out[0]),
                        64'((pos >> (sel - 1)) & 1));
            end
        end
        per_out[27] = 1'b0;
        #1;
        chk("R9 gated by per_out", 64'(pin_out[0]), 64'd0);
    endtask

    initial begin
        #100000000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_shift();
        t_pca();
        t_analog();
        t_odmode();
        t_readback();
        t_random();
        t_clkdiv();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule